// File: doc/BRIEF.md
# CRC-8 Remainder Combine Unit

This unit joins two CRC-8 results into the CRC of the concatenated message. It does not read the data again. The CRC is the remainder of the message multiplied by x^8 and divided by x^8+x^2+x+1. The remainder register starts at zero and no final XOR is applied. A 64-byte datapath can compute one remainder per 8-byte slice in parallel and then merge the slices pairwise with this unit.

The unit takes the remainder of the leading segment, the remainder of the trailing segment and the byte count of the trailing segment. It multiplies the leading remainder, as a GF(2) polynomial, by the constant x^(8·n) mod P, where n is that byte count. The constants for every n are computed at elaboration time. The unit then reduces the 15-bit carryless product modulo P with a chain of conditional subtractions. Finally it XORs in the trailing remainder.

Inputs are taken with a valid/ready handshake. The result comes out of a register one cycle after a transfer, and it is held until the consumer takes it.

Top module: `crc8_combine`

## Requirements
- R1: For a trailing byte count n in 1..8, the result equals the CRC (zero start, no final XOR, P = 0x107, processed MSB first) of the leading bytes followed by the trailing bytes. It therefore equals ((lead · x^(8n)) mod P) XOR trail.
- R2: A trailing byte count of 0 gives lead XOR trail.
- R3: A trailing byte count of 9 to 15 is handled the same as a count of 8.
- R4: When `in_valid` and `in_ready` are both high at a rising edge, the result appears on `res_crc` with `res_valid` high after that same edge.
- R5: While `res_valid` is high and `res_ready` is low, `in_ready` is low. During that time `res_crc` does not change, and any input presented is ignored.
- R6: The result is consumed when `res_valid` and `res_ready` are both high at an edge. If no new transfer happens at that edge, `res_valid` goes low.
- R7: While `rst` is high, and after it is released, `res_valid` and `res_crc` are 0 and `in_ready` is 1.
- R8: The result is always a fully reduced 8-bit remainder. Examples: lead 0xF3 with trail 0x15 and count 1 gives 0xC2; lead 0x1B with trail 0x15 and count 1 gives 0x54.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input operands are valid |
| in_ready | output | 1 | Unit can accept operands |
| lead_crc | input | 8 | Remainder of the leading segment |
| trail_crc | input | 8 | Remainder of the trailing segment |
| trail_len | input | 4 | Byte count of the trailing segment |
| res_valid | output | 1 | Combined remainder is valid |
| res_ready | input | 1 | Consumer takes the result |
| res_crc | output | 8 | Combined remainder |

## Verification
The bench builds the unit with its default parameters: an 8-bit remainder, polynomial 0x07, up to 8 bytes and a 4-bit count. With these values every leading remainder (all 256) can be swept against every count from 0 to 15. That covers the zero-count pass-through, all eight power constants and the clamp for counts above 8. For each sweep point the expected value comes from a bit-serial shift of the leading remainder. A second set of checks builds real byte messages, splits them at several points and compares the merged result with the serial CRC of the whole message. A back-pressure sequence shows that a held result is stable and that a second operand is not taken until the first result is consumed.

// File: rtl/crc8c_pkg.sv
package crc8c_pkg;

    localparam int unsigned DEF_W         = 8;
    localparam logic [31:0] DEF_POLY      = 32'h07;
    localparam int unsigned DEF_MAX_BYTES = 8;
    localparam int unsigned DEF_LEN_W     = 4;

    // x^nbits mod P, P = x^w + poly (poly holds the low w coefficients)
    function automatic logic [31:0] pow_x_mod(input int unsigned w,
                                              input logic [31:0] poly,
                                              input int unsigned nbits);
        logic [31:0] r;
        logic [31:0] mask;
        logic        msb;
        mask = (32'h1 << w) - 32'h1;
        r    = 32'h1;
        for (int unsigned i = 0; i < nbits; i++) begin
            msb = r[w-1];
            r   = (r << 1) & mask;
            if (msb) r = r ^ (poly & mask);
        end
        return r;
    endfunction

endpackage

// File: rtl/crc_pow_table.sv
module crc_pow_table #(
    parameter int unsigned W         = crc8c_pkg::DEF_W,
    parameter logic [31:0] POLY      = crc8c_pkg::DEF_POLY,
    parameter int unsigned MAX_BYTES = crc8c_pkg::DEF_MAX_BYTES,
    parameter int unsigned LEN_W     = crc8c_pkg::DEF_LEN_W
) (
    input  logic [LEN_W-1:0] nbytes,
    output logic [W-1:0]     factor
);
    logic [W-1:0]     tbl [0:MAX_BYTES];
    logic [LEN_W-1:0] sel;

    for (genvar k = 0; k <= MAX_BYTES; k++) begin : g_ent
        localparam logic [31:0] KVAL = crc8c_pkg::pow_x_mod(W, POLY, 8 * k);
        assign tbl[k] = KVAL[W-1:0];
    end

    always_comb begin
        if (nbytes > LEN_W'(MAX_BYTES)) sel = LEN_W'(MAX_BYTES);
        else                            sel = nbytes;
        factor = tbl[sel];
    end
endmodule

// File: rtl/crc_clmul.sv
module crc_clmul #(
    parameter int unsigned W = crc8c_pkg::DEF_W,
    localparam int unsigned PW = 2 * W - 1
) (
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    output logic [PW-1:0] prod
);
    logic [PW-1:0] acc [0:W];

    assign acc[0] = '0;
    for (genvar i = 0; i < W; i++) begin : g_row
        assign acc[i+1] = acc[i] ^ (b[i] ? (PW'(a) << i) : '0);
    end
    assign prod = acc[W];
endmodule

// File: rtl/crc_reduce.sv
module crc_reduce #(
    parameter int unsigned W    = crc8c_pkg::DEF_W,
    parameter logic [31:0] POLY = crc8c_pkg::DEF_POLY,
    localparam int unsigned PW    = 2 * W - 1,
    localparam int unsigned STEPS = W - 1
) (
    input  logic [PW-1:0] prod,
    output logic [W-1:0]  rem
);
    for (genvar s = 0; s < STEPS; s++) begin : g_step
        localparam int unsigned HI = PW - 1 - s;
        localparam logic [HI-1:0] TAP = HI'(POLY & ((32'h1 << W) - 32'h1)) << (HI - W);
        logic [HI:0]   cur;
        logic [HI-1:0] nxt;
        if (s == 0) begin : g_first
            assign cur = prod;
        end else begin : g_next
            assign cur = g_step[s-1].nxt;
        end
        assign nxt = cur[HI-1:0] ^ (cur[HI] ? TAP : '0);
    end
    assign rem = g_step[STEPS-1].nxt;
endmodule

// File: rtl/crc8_combine.sv
module crc8_combine #(
    parameter int unsigned W         = crc8c_pkg::DEF_W,
    parameter logic [31:0] POLY      = crc8c_pkg::DEF_POLY,
    parameter int unsigned MAX_BYTES = crc8c_pkg::DEF_MAX_BYTES,
    parameter int unsigned LEN_W     = crc8c_pkg::DEF_LEN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [W-1:0]     lead_crc,
    input  logic [W-1:0]     trail_crc,
    input  logic [LEN_W-1:0] trail_len,
    output logic             res_valid,
    input  logic             res_ready,
    output logic [W-1:0]     res_crc
);
    localparam int unsigned PW = 2 * W - 1;

    logic [W-1:0]  factor;
    logic [PW-1:0] prod;
    logic [W-1:0]  moved;
    logic          take;

    crc_pow_table #(.W(W), .POLY(POLY), .MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) i_tbl (
        .nbytes (trail_len),
        .factor (factor)
    );

    crc_clmul #(.W(W)) i_mul (
        .a    (lead_crc),
        .b    (factor),
        .prod (prod)
    );

    crc_reduce #(.W(W), .POLY(POLY)) i_red (
        .prod (prod),
        .rem  (moved)
    );

    assign in_ready = !res_valid || res_ready;
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_crc   <= '0;
        end else if (take) begin
            res_valid <= 1'b1;
            res_crc   <= moved ^ trail_crc;
        end else if (res_ready) begin
            res_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/crc8_combine_chk.sv
module crc8_combine_chk #(
    parameter int unsigned W     = crc8c_pkg::DEF_W,
    parameter int unsigned LEN_W = crc8c_pkg::DEF_LEN_W
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic [W-1:0]     lead_crc,
    input logic [W-1:0]     trail_crc,
    input logic [LEN_W-1:0] trail_len,
    input logic             res_valid,
    input logic             res_ready,
    input logic [W-1:0]     res_crc
);
    // R2
    zero_len_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && trail_len == '0) |=> (res_crc == $past(lead_crc ^ trail_crc)));

    // R4
    accept_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> res_valid);

    // R5
    hold_blocks_input_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ready) |-> !in_ready);

    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_crc)));

    // R6
    drain_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_ready && !in_valid) |=> !res_valid);

    // R7
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> (!res_valid && res_crc == '0));
endmodule

bind crc8_combine crc8_combine_chk #(.W(W), .LEN_W(LEN_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .lead_crc  (lead_crc),
    .trail_crc (trail_crc),
    .trail_len (trail_len),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .res_crc   (res_crc)
);

// File: tb/test_crc8_combine.sv
module test_crc8_combine;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic       in_ready;
    logic [7:0] lead_crc;
    logic [7:0] trail_crc;
    logic [3:0] trail_len;
    logic       res_valid;
    logic       res_ready;
    logic [7:0] res_crc;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    crc8_combine i_crc8_combine (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .lead_crc(lead_crc), .trail_crc(trail_crc), .trail_len(trail_len),
        .res_valid(res_valid), .res_ready(res_ready), .res_crc(res_crc)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] shift_bits(input logic [7:0] r0, input int nbits);
        logic [7:0] r;
        logic       m;
        r = r0;
        for (int i = 0; i < nbits; i++) begin
            m = r[7];
            r = {r[6:0], 1'b0};
            if (m) r = r ^ 8'h07;
        end
        return r;
    endfunction

    function automatic logic [7:0] expect_comb(input logic [7:0] a, input logic [7:0] b,
                                               input int n);
        int nn;
        nn = (n > 8) ? 8 : n;
        return shift_bits(a, 8 * nn) ^ b;
    endfunction

    function automatic logic [7:0] crc_span(input logic [7:0] msg [0:15], input int from,
                                            input int upto);
        logic [7:0] r;
        r = 8'h00;
        for (int i = from; i < upto; i++) r = shift_bits(r ^ msg[i], 8);
        return r;
    endfunction

    task automatic send(input logic [7:0] a, input logic [7:0] b, input int n);
        @(negedge clk);
        in_valid  = 1'b1;
        lead_crc  = a;
        trail_crc = b;
        trail_len = 4'(n);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] msg [0:15];
        logic [7:0] held;
        logic [7:0] bval;
        rst = 1'b1; in_valid = 1'b0; res_ready = 1'b1;
        lead_crc = 8'h00; trail_crc = 8'h00; trail_len = 4'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R7: reset state
        check("R7 res_valid", {31'd0, res_valid}, 0);
        check("R7 res_crc", {24'd0, res_crc}, 0);
        check("R7 in_ready", {31'd0, in_ready}, 1);
        rst = 1'b0;
        @(negedge clk);
        check("R7 after release", {31'd0, res_valid}, 0);

        // R8 worked examples
        send(8'hF3, 8'h15, 1);
        check("R8 F3/15 n1", {24'd0, res_crc}, 32'hC2);
        check("R4 valid after accept", {31'd0, res_valid}, 1);
        @(negedge clk);
        // R6: consumed, nothing new
        check("R6 drain", {31'd0, res_valid}, 0);
        send(8'h1B, 8'h15, 1);
        check("R8 1B/15 n1", {24'd0, res_crc}, 32'h54);

        // R1 R2 R3: full sweep over lead remainder and count
        for (int n = 0; n < 16; n++) begin
            for (int a = 0; a < 256; a++) begin
                bval = 8'((a * 37 + n * 11 + 5) & 255);
                send(8'(a), bval, n);
                if (n == 0)     check("R2 zero count", {24'd0, res_crc}, {24'd0, expect_comb(8'(a), bval, 0)});
                else if (n > 8) check("R3 clamp", {24'd0, res_crc}, {24'd0, expect_comb(8'(a), bval, n)});
                else            check("R1 sweep", {24'd0, res_crc}, {24'd0, expect_comb(8'(a), bval, n)});
            end
        end

        // R1: split real messages and compare with whole-message CRC
        for (int t = 0; t < 40; t++) begin
            int la;
            int lb;
            la = 1 + (t % 7);
            lb = 1 + ((t * 3) % 8);
            for (int i = 0; i < 16; i++) msg[i] = 8'((t * 53 + i * 29 + i * i) & 255);
            send(crc_span(msg, 0, la), crc_span(msg, la, la + lb), lb);
            check("R1 split message", {24'd0, res_crc}, {24'd0, crc_span(msg, 0, la + lb)});
        end

        // R5: back-pressure holds result and blocks input
        @(negedge clk);
        res_ready = 1'b0;
        send(8'h5A, 8'h3C, 3);
        held = expect_comb(8'h5A, 8'h3C, 3);
        check("R5 held value", {24'd0, res_crc}, {24'd0, held});
        check("R5 in_ready low", {31'd0, in_ready}, 0);
        in_valid = 1'b1; lead_crc = 8'hA7; trail_crc = 8'h11; trail_len = 4'd5;
        repeat (3) begin
            @(negedge clk);
            check("R5 ignored input", {24'd0, res_crc}, {24'd0, held});
            check("R5 still valid", {31'd0, res_valid}, 1);
        end
        res_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R6 replace on consume", {24'd0, res_crc}, {24'd0, expect_comb(8'hA7, 8'h11, 5)});
        check("R4 new valid", {31'd0, res_valid}, 1);
        @(negedge clk);
        check("R6 drain final", {31'd0, res_valid}, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule